// File: doc/BRIEF.md
# Triggered Arbitrary Waveform Sequencer

This block stores a list of DAC sample codes written by a host during setup and replays them, in index order, onto a parallel sample bus. The samples are played at a programmable rate: one sample is held for 2^E clock cycles, where E runs from 0 to 15. This gives a division of the base clock of up to 32768. Playback starts on a trigger. The trigger is either a shared start strobe that all sequencer instances see, or a rising edge on a per-instance external line. An optional start delay, counted in sample periods, lets several instances be offset against each other. A configurable last index allows waveforms shorter than the memory to be played.

In single-shot mode the sequencer stops after the last index and drives a programmable rest code. In periodic mode it wraps back to index 0 until a halt is applied. In sync-source mode the sample bus stays at the rest code. Instead, the block emits a one-cycle pulse at the start of every pass, which can trigger capture logic or other sequencers.

The controller is a four-state machine with these states:
- IDLE: after reset or halt.
- WAIT: the start delay is running.
- PLAY: samples are being emitted.
- DONE: a single-shot pass has finished.

Its transitions are:
- start: IDLE or DONE to WAIT, or to PLAY when the delay is 0.
- delay_end: WAIT to PLAY.
- wrap: PLAY to PLAY, in periodic mode.
- finish: PLAY to DONE, in single-shot mode.
- halt: any state to IDLE.

Top module: `awg_sequencer`

## Requirements
- R1: After reset, `dac_out` equals `cfg_rest`, and `busy`, `done` and `sync_out` are 0.
- R2: A host write with `mem_we`=1 while `busy`=0 stores `mem_wdata` at index `mem_addr`, and that value is played when the index is reached.
- R3: A host write while `busy`=1 leaves the stored sample unchanged.
- R4: With `cfg_ext_sel`=0, a `glb_start` high at a clock edge in IDLE or DONE starts a pass. With a zero delay, sample 0 appears on `dac_out` right after that edge and `busy` rises.
- R5: With `cfg_ext_sel`=1, `glb_start` is ignored. A rising edge of `ext_trig` (high at an edge, low at the previous one) starts a pass. A level held high does not restart.
- R6: Each sample is held for exactly 2^`cfg_div_exp` clock cycles, and the divider phase is reset by the trigger.
- R7: With `cfg_delay`=D, the first sample appears D·2^`cfg_div_exp` cycles after the trigger edge, and `busy`=1 during the wait.
- R8: With `cfg_periodic`=0, after sample `cfg_last_idx` has been held for one period, `dac_out` returns to `cfg_rest`, `busy`=0 and `done`=1. Done persists until the next start.
- R9: With `cfg_periodic`=1, index `cfg_last_idx` is followed by index 0, with no gap.
- R10: With `cfg_sync_mode`=1, `dac_out` stays at `cfg_rest`. `sync_out` is high for one cycle at the start of every pass (the first sample slot and each wrap).
- R11: `halt` at a clock edge returns the block to IDLE: `busy`=0, `done`=0, `dac_out`=`cfg_rest`, and it has priority over a trigger.
- R12: Triggers that arrive while `busy`=1 are ignored, and the running pass continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_we | input | 1 | Host sample write strobe |
| mem_addr | input | ADDR_W | Host sample write index |
| mem_wdata | input | SAMPLE_W | Host sample write code |
| cfg_div_exp | input | EXP_W | Sample period exponent, period = 2^value cycles |
| cfg_periodic | input | 1 | 1 = repeat, 0 = single shot |
| cfg_ext_sel | input | 1 | 1 = start on external edge, 0 = start on shared strobe |
| cfg_sync_mode | input | 1 | 1 = emit pass-start pulses instead of samples |
| cfg_delay | input | DELAY_W | Start delay in sample periods |
| cfg_last_idx | input | ADDR_W | Index of the final sample of a pass |
| cfg_rest | input | SAMPLE_W | Code driven when not playing |
| glb_start | input | 1 | Shared start strobe |
| ext_trig | input | 1 | External trigger line |
| halt | input | 1 | Stop and return to idle |
| dac_out | output | SAMPLE_W | Sample bus to the converter |
| sync_out | output | 1 | Pass-start pulse in sync-source mode |
| busy | output | 1 | Waiting or playing |
| done | output | 1 | Single-shot pass finished |

## Verification
The assertions assume that every `cfg_*` input stays constant from the trigger until the block is back in IDLE or DONE. The index bound and the sync-pulse checks rely on that assumption. The assertions also assume that `halt` is never raised in the same cycle as a wanted start.

The stimulus respects these assumptions. It changes configuration only on a falling edge while the block is idle or done, and it applies halt only after the observed window of a run has closed. Each run picks a small last index inside a sixteen-entry window that was written beforehand. The stray start and the host write issued during a run both fall inside the busy period.

// File: rtl/awg_pkg.sv
package awg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PLAY = 2'd2,
        ST_DONE = 2'd3
    } awg_state_e;
endpackage

// File: rtl/awg_trig_sel.sv
module awg_trig_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic glb_start,
    input  logic ext_trig,
    output logic fire
);
    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    // External source reacts to an edge; shared strobe is a level pulse
    assign fire = ext_sel ? (ext_trig & ~ext_q) : glb_start;

    AST_EXT_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && ext_q && ext_trig) |-> !fire); // R5
endmodule

// File: rtl/awg_tick_gen.sv
module awg_tick_gen #(
    parameter int MAX_EXP = 15,
    parameter int EXP_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [EXP_W-1:0] div_exp,
    output logic             tick
);
    localparam int CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((32'd1 << div_exp) - 32'd1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_exp != '0 && $stable(div_exp)) |=> !tick); // R6
endmodule

// File: rtl/awg_sample_store.sv
module awg_sample_store #(
    parameter int SAMPLE_W = 12,
    parameter int ADDR_W   = 11
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [SAMPLE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMPLE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/awg_sequencer.sv
module awg_sequencer
    import awg_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int ADDR_W      = 11,
    parameter int MAX_DIV_EXP = 15,
    parameter int DELAY_W     = 16,
    localparam int EXP_W      = $clog2(MAX_DIV_EXP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mem_we,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic [SAMPLE_W-1:0] mem_wdata,
    input  logic [EXP_W-1:0]    cfg_div_exp,
    input  logic                cfg_periodic,
    input  logic                cfg_ext_sel,
    input  logic                cfg_sync_mode,
    input  logic [DELAY_W-1:0]  cfg_delay,
    input  logic [ADDR_W-1:0]   cfg_last_idx,
    input  logic [SAMPLE_W-1:0] cfg_rest,
    input  logic                glb_start,
    input  logic                ext_trig,
    input  logic                halt,
    output logic [SAMPLE_W-1:0] dac_out,
    output logic                sync_out,
    output logic                busy,
    output logic                done
);
    awg_state_e state_q, state_d;

    logic [ADDR_W-1:0]   idx_q;
    logic [DELAY_W-1:0]  dly_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic                sync_q;

    logic                trig_fire, tick, accept, busy_w;
    logic                dly_hit, wrap, enter_play, restart, advance;
    logic [ADDR_W-1:0]   rd_addr;
    logic [SAMPLE_W-1:0] rd_data;

    awg_trig_sel u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sel   (cfg_ext_sel),
        .glb_start (glb_start),
        .ext_trig  (ext_trig),
        .fire      (trig_fire)
    );

    assign busy_w = (state_q == ST_WAIT) || (state_q == ST_PLAY);
    assign accept = trig_fire && !halt &&
                    ((state_q == ST_IDLE) || (state_q == ST_DONE));

    awg_tick_gen #(
        .MAX_EXP (MAX_DIV_EXP),
        .EXP_W   (EXP_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (busy_w),
        .div_exp (cfg_div_exp),
        .tick    (tick)
    );

    assign dly_hit    = tick && (dly_q == cfg_delay - DELAY_W'(1));
    assign wrap       = tick && (idx_q == cfg_last_idx);
    assign enter_play = !halt && ((accept && cfg_delay == '0) ||
                                  (state_q == ST_WAIT && dly_hit));
    assign restart    = enter_play ||
                        (state_q == ST_PLAY && wrap && cfg_periodic && !halt);
    assign advance    = (state_q == ST_PLAY) && tick && !wrap && !halt;
    assign rd_addr    = restart ? '0 : idx_q + ADDR_W'(1);

    awg_sample_store #(
        .SAMPLE_W (SAMPLE_W),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we && !busy_w),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (halt) begin
            state_d = ST_IDLE;                                   // halt
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE:
                    if (accept)
                        state_d = (cfg_delay == '0) ? ST_PLAY : ST_WAIT; // start
                ST_WAIT:
                    if (dly_hit) state_d = ST_PLAY;              // delay_end
                ST_PLAY:
                    if (wrap && !cfg_periodic) state_d = ST_DONE; // finish
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            dly_q    <= '0;
            sample_q <= '0;
            sync_q   <= 1'b0;
        end else begin
            if (restart)      idx_q <= '0;
            else if (advance) idx_q <= idx_q + ADDR_W'(1);

            if (accept)                          dly_q <= '0;
            else if (state_q == ST_WAIT && tick) dly_q <= dly_q + DELAY_W'(1);

            if (restart || advance) sample_q <= rd_data;

            sync_q <= restart && cfg_sync_mode;
        end
    end

    assign dac_out  = (state_q == ST_PLAY && !cfg_sync_mode) ? sample_q : cfg_rest;
    assign sync_out = sync_q;
    assign busy     = busy_w;
    assign done     = (state_q == ST_DONE);

    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state_q == ST_IDLE)); // R11
    AST_SYNC_IN_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> (state_q == ST_PLAY)); // R10
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAY && $stable(cfg_last_idx)) |-> (idx_q <= cfg_last_idx)); // R9
    AST_BUSY_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> $past(trig_fire)); // R12
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !halt && !trig_fire) |=> (state_q == ST_DONE)); // R8
endmodule

// File: tb/awg_sequencer_bench.sv
`timescale 1ns/1ps
module awg_sequencer_bench;
    localparam int SW = 12;
    localparam int AW = 11;
    localparam int EW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [SW-1:0] mem_wdata = '0;
    logic [EW-1:0] cfg_div_exp = '0;
    logic          cfg_periodic = 1'b0;
    logic          cfg_ext_sel = 1'b0;
    logic          cfg_sync_mode = 1'b0;
    logic [DW-1:0] cfg_delay = '0;
    logic [AW-1:0] cfg_last_idx = '0;
    logic [SW-1:0] cfg_rest = 12'h800;
    logic          glb_start = 1'b0;
    logic          ext_trig = 1'b0;
    logic          halt = 1'b0;
    logic [SW-1:0] dac_out;
    logic          sync_out, busy, done;

    always #2.5 clk = ~clk;

    awg_sequencer u_awg_sequencer (
        .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cfg_div_exp(cfg_div_exp), .cfg_periodic(cfg_periodic),
        .cfg_ext_sel(cfg_ext_sel), .cfg_sync_mode(cfg_sync_mode), .cfg_delay(cfg_delay),
        .cfg_last_idx(cfg_last_idx), .cfg_rest(cfg_rest), .glb_start(glb_start),
        .ext_trig(ext_trig), .halt(halt), .dac_out(dac_out), .sync_out(sync_out),
        .busy(busy), .done(done)
    );

    typedef struct {
        int    cyc;
        int    dac;
        bit    sync;
        bit    bsy;
        bit    dn;
        string req;
    } exp_t;

    exp_t  sb_q[$];
    exp_t  mon_e;
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    int    model [16];

    always @(posedge clk) cyc++;

    // Monitor: pop and compare each expected item in its cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
            mon_e = sb_q.pop_front();
            n_cmp++;
            if (int'(dac_out) != mon_e.dac || sync_out != mon_e.sync ||
                busy != mon_e.bsy || done != mon_e.dn) begin
                n_bad++;
                $display("FAIL %s cyc %0d: dac=%h sync=%b busy=%b done=%b expected dac=%h sync=%b busy=%b done=%b",
                         mon_e.req, cyc, dac_out, sync_out, busy, done,
                         mon_e.dac, mon_e.sync, mon_e.bsy, mon_e.dn);
            end
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = SW'(d);
        @(negedge clk);
        mem_we = 1'b0;
        model[a] = d;
    endtask

    // Driver: configures, triggers, pushes expected items, optionally pokes
    task automatic run_case(input int d, input int ex, input int l, input bit per,
                            input bit syn, input bit use_ext, input int obs,
                            input int poke_k, input string req);
        int n, dn, base;
        @(negedge clk);
        cfg_delay = DW'(d); cfg_div_exp = EW'(ex); cfg_last_idx = AW'(l);
        cfg_periodic = per; cfg_sync_mode = syn; cfg_ext_sel = use_ext;
        @(negedge clk);
        if (use_ext) ext_trig = 1'b1; else glb_start = 1'b1;
        base = cyc;
        n = 1 << ex;
        dn = d * n;
        for (int k = 0; k < obs; k++) begin
            exp_t e;
            int j, ph, idx;
            e.cyc = base + 1 + k; e.req = req;
            e.sync = 1'b0; e.dac = int'(cfg_rest); e.bsy = 1'b1; e.dn = 1'b0;
            if (k >= dn) begin
                j = (k - dn) / n; ph = (k - dn) % n;
                if (!per && j > l) begin
                    e.bsy = 1'b0; e.dn = 1'b1;
                end else begin
                    idx = per ? (j % (l + 1)) : j;
                    if (!syn) e.dac = model[idx];
                    e.sync = syn && ph == 0 && idx == 0;
                end
            end
            sb_q.push_back(e);
        end
        for (int k = 0; k < obs + 1; k++) begin
            @(negedge clk);
            glb_start = 1'b0; mem_we = 1'b0;
            if (k == poke_k) begin
                // R12: stray start while busy; R3: write while busy
                glb_start = 1'b1;
                mem_we = 1'b1; mem_addr = '0; mem_wdata = 12'h5A5;
            end
        end
        ext_trig = 1'b0;
    endtask

    task automatic do_halt;
        @(negedge clk);
        halt = 1'b1;
        glb_start = !cfg_ext_sel;    // R11: halt outranks a simultaneous start
        @(negedge clk);
        halt = 1'b0; glb_start = 1'b0;
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 dac", int'(dac_out), int'(cfg_rest));
        chk("R11 sync", int'(sync_out), 0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        chk("R1 dac", int'(dac_out), 12'h800);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 sync", int'(sync_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: load samples while idle
        for (int i = 0; i < 16; i++) wr(i, 12'h100 + i * 37);
        // R4 R8: shared start, no delay, single shot, full rate
        run_case(0, 0, 3, 1'b0, 1'b0, 1'b0, 8, -1, "R4/R8/R2");
        // R6 R7 R12 R3: delay and divided rate with stray start and write
        run_case(3, 2, 2, 1'b0, 1'b0, 1'b0, 28, 2, "R6/R7/R12");
        // R9 R3: periodic wrap; sample 0 must still be the pre-run value
        run_case(0, 1, 2, 1'b1, 1'b0, 1'b0, 16, -1, "R9/R3");
        do_halt();
        // R10: sync-source mode
        cfg_rest = 12'h7F0;
        run_case(1, 0, 3, 1'b1, 1'b1, 1'b0, 12, -1, "R10");
        do_halt();
        // R5: shared strobe ignored with external selection
        @(negedge clk);
        cfg_ext_sel = 1'b1; cfg_sync_mode = 1'b0;
        glb_start = 1'b1;
        @(negedge clk);
        glb_start = 1'b0;
        chk("R5 strobe ignored", int'(busy), 0);
        run_case(1, 1, 1, 1'b0, 1'b0, 1'b1, 10, -1, "R5");
        // R6 R7: coarser divider with a longer delay
        run_case(2, 5, 1, 1'b0, 1'b0, 1'b0, 136, -1, "R6/R7");
        @(negedge clk);
        chk("R8 done held", int'(done), 1);
        summary();
    end
endmodule